// File: doc/BRIEF.md
# Ghost Road Filter

This block sits on a stream of candidate roads produced by a pattern matcher that accepts roads with some layers absent. Because absent layers are tolerated, one physical track can light up several roads that differ only in layers with no data. The filter sees each road of an event as it arrives. In the same cycle it compares the road against every road already kept for that event, using one comparator per stored entry. A road that agrees with a kept road is dropped. Any other road is forwarded downstream and added to the store.

A road is six layer words of 12 bits, plus a six-bit mask whose set bits mark layers with no data. Two roads agree when their words are equal on every layer that neither mask flags. A flagged layer acts as a wildcard on either side. End of event travels in the same stream as a marker beat. The marker is forwarded downstream and empties the store for the next event. A separate clear pin empties the store at any time.

Both streams use valid/ready. A beat moves when valid and ready are both high on a rising edge. Input ready is high when the single output register is empty or is being drained that cycle, and low while the clear pin is high. A stalled output keeps its data steady. Output appears one cycle after the input beat is accepted.

Top module: `road_ghost_filter`

## Requirements
- R1: After reset, out_valid and overflow are 0 and in_ready is 1.
- R2: The first road of an event is forwarded with its words and mask unchanged, with out_valid high in the cycle after the input beat is accepted. Layer l occupies bits [12l+11:12l] of the road bus, and mask bit l belongs to layer l.
- R3: A road whose words equal those of a kept road of the same event on every layer is dropped and never appears on the output.
- R4: A layer whose mask bit is 1 in either the new road or the kept road is excluded from the comparison. A road with all six bits set is therefore dropped whenever the store holds any road.
- R5: A road that differs from every kept road on at least one layer present in both is forwarded.
- R6: While out_valid is high and out_ready is low, the output beat holds steady and in_ready is 0. A waiting input beat is taken in the cycle the output drains.
- R7: A beat with in_eoe = 1 is a marker whose road fields are ignored. It is forwarded with out_eoe = 1 and empties the store, so a road repeated in the next event is forwarded.
- R8: The store keeps up to 64 roads. Once it is full, every further road of the event is forwarded without comparison and overflow goes to 1.
- R9: Overflow stays 1 until an end-of-event marker is accepted or evt_clear is raised.
- R10: While evt_clear is high, in_ready is 0. After the clear, the store is empty and overflow is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_clear | input | 1 | Empties the road store and clears overflow |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Filter can take an input beat |
| in_road | input | 72 | Six 12-bit layer words, layer 0 in the low bits |
| in_miss | input | 6 | Missing-layer mask, bit l for layer l |
| in_eoe | input | 1 | Beat is an end-of-event marker |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_road | output | 72 | Forwarded road words |
| out_miss | output | 6 | Forwarded missing-layer mask |
| out_eoe | output | 1 | Forwarded end-of-event marker |
| overflow | output | 1 | Store filled during this event |

## Verification
The bench targets wildcard handling from both sides. It sends a road with a layer missing against a complete kept road, and a complete road against a kept road that has a layer missing. A filter that honoured only one of the two masks would forward ghosts in one of these cases.

It checks that an event boundary forgets the earlier roads, so a repeated road is forwarded again. A filter that failed to clear the store would drop valid roads from the next event.

It fills the store to exactly 64 roads and then sends a duplicate. An off-by-one in the fill count would either drop that road or fail to raise overflow.

Finally, it holds the output stalled while a second beat waits. A stage that lost or overwrote data under back-pressure would show the wrong road or a changing road.

// File: rtl/rgf_pkg.sv
package rgf_pkg;
  localparam int unsigned LAYERS_DEF = 6;
  localparam int unsigned WORD_W_DEF = 12;
  localparam int unsigned DEPTH_DEF  = 64;
endpackage

// File: rtl/road_store.sv
module road_store #(
  parameter int unsigned LAYERS = rgf_pkg::LAYERS_DEF,
  parameter int unsigned WORD_W = rgf_pkg::WORD_W_DEF,
  parameter int unsigned DEPTH  = rgf_pkg::DEPTH_DEF,
  localparam int unsigned RW    = LAYERS * WORD_W,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [RW-1:0]     key_road,
  input  logic [LAYERS-1:0] key_miss,
  output logic              hit,
  output logic              full
);
  logic [CW-1:0]     fill_q;
  logic [DEPTH-1:0]  used_q;
  logic [DEPTH-1:0]  hit_vec;
  logic [RW-1:0]     ent_road [DEPTH];
  logic [LAYERS-1:0] ent_miss [DEPTH];

  assign full = (fill_q == CW'(DEPTH));
  assign hit  = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fill_q <= '0;
    else if (clr)              fill_q <= '0;
    else if (wr_en && !full)   fill_q <= fill_q + 1'b1;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [LAYERS-1:0] agree;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  used_q[e] <= 1'b0;
      else if (clr)                                used_q[e] <= 1'b0;
      else if (wr_en && fill_q == CW'(e))          used_q[e] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_en && fill_q == CW'(e)) begin
        ent_road[e] <= key_road;
        ent_miss[e] <= key_miss;
      end
    end

    for (genvar l = 0; l < LAYERS; l++) begin : g_lay
      assign agree[l] = ent_miss[e][l] | key_miss[l] |
                        (ent_road[e][l*WORD_W +: WORD_W] == key_road[l*WORD_W +: WORD_W]);
    end

    assign hit_vec[e] = used_q[e] & (&agree);
  end
endmodule

// File: rtl/road_out_stage.sv
module road_out_stage #(
  parameter int unsigned DW = 79
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          space,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign space = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_valid <= 1'b0;
    else if (space) out_valid <= push;
  end

  always_ff @(posedge clk) begin
    if (space && push) out_data <= push_data;
  end
endmodule

// File: rtl/road_ghost_filter.sv
module road_ghost_filter #(
  parameter int unsigned LAYERS = rgf_pkg::LAYERS_DEF,
  parameter int unsigned WORD_W = rgf_pkg::WORD_W_DEF,
  parameter int unsigned DEPTH  = rgf_pkg::DEPTH_DEF,
  localparam int unsigned RW    = LAYERS * WORD_W,
  localparam int unsigned BW    = RW + LAYERS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_clear,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RW-1:0]     in_road,
  input  logic [LAYERS-1:0] in_miss,
  input  logic              in_eoe,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RW-1:0]     out_road,
  output logic [LAYERS-1:0] out_miss,
  output logic              out_eoe,
  output logic              overflow
);
  logic space, fire, road_fire, hit, full, keep, pass, store_clr;
  logic [BW-1:0] out_beat;

  assign in_ready  = space && !evt_clear;
  assign fire      = in_valid && in_ready;
  assign road_fire = fire && !in_eoe;
  assign keep      = road_fire && !hit && !full;
  assign pass      = fire && (in_eoe || full || !hit);
  assign store_clr = evt_clear || (fire && in_eoe);

  road_store #(.LAYERS(LAYERS), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (store_clr),
    .wr_en    (keep),
    .key_road (in_road),
    .key_miss (in_miss),
    .hit      (hit),
    .full     (full)
  );

  road_out_stage #(.DW(BW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (pass),
    .push_data ({in_eoe, in_miss, in_road}),
    .space     (space),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_beat)
  );

  assign {out_eoe, out_miss, out_road} = out_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 overflow <= 1'b0;
    else if (store_clr)         overflow <= 1'b0;
    else if (road_fire && full) overflow <= 1'b1;
  end
endmodule

// File: rtl/road_ghost_filter_chk.sv
module road_ghost_filter_chk #(
  parameter int unsigned RW = 72,
  parameter int unsigned LAYERS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_clear,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_eoe,
  input logic              out_valid,
  input logic              out_ready,
  input logic [RW-1:0]     out_road,
  input logic [LAYERS-1:0] out_miss,
  input logic              out_eoe,
  input logic              overflow
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_road) && $stable(out_miss) && $stable(out_eoe));

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_eoe_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_eoe |=> out_valid && out_eoe);

  p_eoe_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_eoe |=> !overflow);

  p_clr_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clear |-> !in_ready);

  p_clr_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clear |=> !overflow);
endmodule

bind road_ghost_filter road_ghost_filter_chk #(.RW(RW), .LAYERS(LAYERS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_clear (evt_clear),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_eoe    (in_eoe),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_road  (out_road),
  .out_miss  (out_miss),
  .out_eoe   (out_eoe),
  .overflow  (overflow)
);

// File: tb/sim_road_ghost_filter.sv
`timescale 1ns/1ps
module sim_road_ghost_filter;
  logic clk = 1'b0, rst_n = 1'b0, evt_clear = 1'b0;
  logic in_valid = 1'b0, in_eoe = 1'b0, out_ready = 1'b1;
  logic [71:0] in_road = '0;
  logic [5:0]  in_miss = '0;
  logic in_ready, out_valid, out_eoe, overflow;
  logic [71:0] out_road;
  logic [5:0]  out_miss;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  road_ghost_filter u0 (
    .clk(clk), .rst_n(rst_n), .evt_clear(evt_clear),
    .in_valid(in_valid), .in_ready(in_ready), .in_road(in_road), .in_miss(in_miss), .in_eoe(in_eoe),
    .out_valid(out_valid), .out_ready(out_ready), .out_road(out_road), .out_miss(out_miss),
    .out_eoe(out_eoe), .overflow(overflow)
  );

  // {seed[7:0], flip_layer[2:0] (7 = none), miss[5:0], eoe, expect_forward}
  localparam logic [18:0] VEC [13] = '{
    {8'd1, 3'd7, 6'b000000, 1'b0, 1'b1},  // R2 first road
    {8'd1, 3'd7, 6'b000000, 1'b0, 1'b0},  // R3 exact duplicate
    {8'd1, 3'd2, 6'b000000, 1'b0, 1'b1},  // R5 differs on layer 2
    {8'd1, 3'd3, 6'b001000, 1'b0, 1'b0},  // R4 new road missing layer 3
    {8'd2, 3'd7, 6'b000000, 1'b0, 1'b1},  // R5
    {8'd2, 3'd0, 6'b000001, 1'b0, 1'b0},  // R4 missing layer 0
    {8'd3, 3'd7, 6'b000100, 1'b0, 1'b1},  // R5 kept with layer 2 missing
    {8'd3, 3'd2, 6'b000000, 1'b0, 1'b0},  // R4 wildcard on kept side
    {8'd9, 3'd7, 6'b111111, 1'b0, 1'b0},  // R4 all missing
    {8'd0, 3'd7, 6'b000000, 1'b1, 1'b1},  // R7 marker
    {8'd1, 3'd7, 6'b000000, 1'b0, 1'b1},  // R7 repeat in new event
    {8'd1, 3'd7, 6'b000000, 1'b0, 1'b0},  // R3
    {8'd0, 3'd7, 6'b000000, 1'b1, 1'b1}   // R7
  };

  function automatic logic [71:0] mk(input logic [7:0] seed, input logic [2:0] flip);
    logic [71:0] r;
    for (int l = 0; l < 6; l++) begin
      r[l*12 +: 12] = {seed, 4'(l)} ^ ((flip == 3'(l)) ? 12'h800 : 12'h000);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic send(input logic [71:0] r, input logic [5:0] m, input logic e);
    in_road = r; in_miss = m; in_eoe = e; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_eoe = 1'b0;
  endtask

  task automatic fill_store(input logic [7:0] base);
    for (int k = 0; k < 64; k++) begin
      send(mk(base + 8'(k), 3'd7), 6'd0, 1'b0);
      chk(out_valid == 1'b1, "R8 fill forward", 80'(out_valid), 80'd1);
    end
    chk(overflow == 1'b0, "R8 no overflow at 64", 80'(overflow), 80'd0);
    send(mk(base, 3'd7), 6'd0, 1'b0);
    chk(out_valid == 1'b1, "R8 duplicate passes when full", 80'(out_valid), 80'd1);
    chk(overflow == 1'b1, "R8 overflow set", 80'(overflow), 80'd1);
    send(mk(base + 8'd1, 3'd7), 6'd0, 1'b0);
    chk(overflow == 1'b1, "R9 overflow sticky", 80'(overflow), 80'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid", 80'(out_valid), 80'd0);
    chk(overflow == 1'b0, "R1 overflow", 80'(overflow), 80'd0);
    chk(in_ready == 1'b1, "R1 in_ready", 80'(in_ready), 80'd1);

    for (int i = 0; i < 13; i++) begin
      logic [71:0] r;
      r = mk(VEC[i][18:11], VEC[i][10:8]);
      send(r, VEC[i][7:2], VEC[i][1]);
      chk(out_valid == VEC[i][0], "R2-R7 vector forward", 80'(out_valid), 80'(VEC[i][0]));
      if (VEC[i][0] && !VEC[i][1])
        chk(out_road == r && out_miss == VEC[i][7:2] && !out_eoe, "R2 data",
            {2'b0, out_miss, out_road}, {2'b0, VEC[i][7:2], r});
      if (VEC[i][0] && VEC[i][1])
        chk(out_eoe == 1'b1, "R7 marker", 80'(out_eoe), 80'd1);
    end

    // R6 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    send(mk(8'd40, 3'd7), 6'd0, 1'b0);
    in_road = mk(8'd41, 3'd7); in_miss = 6'd0; in_valid = 1'b1;
    #1;
    chk(out_valid == 1'b1 && in_ready == 1'b0, "R6 stall", {78'b0, out_valid, in_ready}, 80'b10);
    repeat (3) @(negedge clk);
    chk(out_road == mk(8'd40, 3'd7) && out_valid, "R6 hold", 80'(out_road), 80'(mk(8'd40, 3'd7)));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_road == mk(8'd41, 3'd7), "R6 waiting beat taken", 80'(out_road), 80'(mk(8'd41, 3'd7)));
    send('0, 6'd0, 1'b1);

    // R8/R9 ended by marker
    fill_store(8'd64);
    send('0, 6'd0, 1'b1);
    chk(overflow == 1'b0, "R9 marker clears overflow", 80'(overflow), 80'd0);

    // R10 evt_clear
    fill_store(8'd128);
    evt_clear = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R10 ready low in clear", 80'(in_ready), 80'd0);
    @(posedge clk);
    @(negedge clk);
    evt_clear = 1'b0;
    chk(overflow == 1'b0, "R10 overflow cleared", 80'(overflow), 80'd0);
    send(mk(8'd128, 3'd7), 6'd0, 1'b0);
    chk(out_valid == 1'b1, "R10 store emptied", 80'(out_valid), 80'd1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule